// File: doc/BRIEF.md
# Secure-Aware Interrupt Acknowledge and Completion Controller

This block is the distributor control and processor-interface logic of a small interrupt controller. It serves one processor and two interrupt groups, and it has a security extension. Interrupt sources raise a one-cycle set pulse that latches a pending bit. Each source also carries a group bit (0 = Group0, 1 = Group1) and a priority. Lower priority values win.

Software uses a word-addressed register bus. Every access carries a secure/non-secure attribute. A read of the acknowledge register returns the ID of the best eligible interrupt and moves it from pending to active. A write of an ID to the completion register retires it. Both operations are filtered by the requester's security state and by the group of the interrupt. The two control registers have banked views. The non-secure view of each is a single-bit alias of the Group1 enable held in the secure word, not a separate copy. The block drives one IRQ line and one FIQ line to the processor.

Register select (`bus_addr`): 0 = distributor control, 1 = processor-interface control, 2 = acknowledge (read), 3 = completion (write), 4 = active bits (read), 5 = pending bits (read). The spurious ID is 1023.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, both control registers read 0, no interrupt is pending or active, `irq_out` and `fiq_out` are low, and an acknowledge read returns 1023.
- R2: A secure write to the distributor control register (select 0) stores bit 0 as the Group0 enable and bit 1 as the Group1 enable, and a secure read returns both bits. A non-secure read returns the Group1 enable at bit 0. A non-secure write changes only the Group1 enable, taken from bit 0.
- R3: The processor-interface control register (select 1) holds, in secure view, bit 0 Group0 enable, bit 1 Group1 enable, bit 2 AckCtl and bit 3 FIQEn. The non-secure view reads and writes only the Group1 enable, at bit 0.
- R4: An interrupt is a candidate when it is pending, not active, and its group is enabled in both control registers. The top candidate has the lowest priority value, and on a tie the lowest ID wins.
- R5: A non-secure acknowledge read never returns a Group0 interrupt. If the top candidate is in Group0, the read returns 1023.
- R6: A secure acknowledge read returns a Group1 top candidate only while AckCtl is 1. Otherwise it returns 1023.
- R7: An acknowledge that returns an ID clears that interrupt's pending bit and sets its active bit. One that returns 1023 changes neither pending nor active bits.
- R8: A completion write (select 3, ID in the low 10 bits) clears the named active bit, with one exception. A non-secure write naming a Group0 interrupt is ignored. A secure write naming a Group1 interrupt completes it even while AckCtl is 0.
- R9: If the top candidate is in Group0 and FIQEn is 1, `fiq_out` is high and `irq_out` is low. If there is any other top candidate, `irq_out` is high and `fiq_out` is low. With no candidate, both are low.
- R10: A set pulse for an interrupt that is already active makes it pending again. It is not a candidate until it is completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = secure requester |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_pend_set | input | N_IRQ | Per-interrupt pending set pulse |
| irq_group | input | N_IRQ | Per-interrupt group bit |
| irq_prio | input | N_IRQ*PRIO_W | Per-interrupt priority, lower wins |
| irq_out | output | 1 | Interrupt request line |
| fiq_out | output | 1 | Fast interrupt request line |

## Verification
A misrouted pending or active bit shows on the ports at once. `irq_out` or `fiq_out` moves in the cycle after the bad update. The next acknowledge read returns a wrong ID or 1023, and the active and pending readbacks differ from the expected masks. A wrongly filtered acknowledge or completion is caught one access later. A second acknowledge, or an active readback, then shows whether the interrupt left the pending set or stayed active. A corrupted banked control bit changes both the alias reads and the line the interrupt takes.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int SEL_W = 3;
    localparam int ID_W  = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [SEL_W-1:0] SEL_DCTL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CCTL = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ACK  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_EOI  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ACTV = 3'd4;
    localparam logic [SEL_W-1:0] SEL_PEND = 3'd5;

    localparam int CC_EN0    = 0;
    localparam int CC_EN1    = 1;
    localparam int CC_ACKCTL = 2;
    localparam int CC_FIQEN  = 3;

    typedef struct packed {
        logic [1:0] dctl;
        logic [3:0] cctl;
    } ctl_state_t;
endpackage

// File: rtl/irq_ctl_bank.sv
module irq_ctl_bank
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [3:0]       wdata,
    input  logic             secure,
    output logic [1:0]       dctl,
    output logic [3:0]       cctl
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (sel == SEL_DCTL) begin
                if (secure) st_d.dctl = wdata[1:0];
                else        st_d.dctl[1] = wdata[0];
            end else if (sel == SEL_CCTL) begin
                if (secure) st_d.cctl = wdata;
                else        st_d.cctl[CC_EN1] = wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dctl = st_q.dctl;
    assign cctl = st_q.cctl;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0]        cand,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    output logic                    found,
    output logic [IDX_W-1:0]        best_id
);
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                found     = 1'b1;
                best_id   = IDX_W'(i);
                best_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [2:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic                    bus_secure,
    output logic [31:0]             bus_rdata,
    input  logic [N_IRQ-1:0]        irq_pend_set,
    input  logic [N_IRQ-1:0]        irq_group,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    output logic                    irq_out,
    output logic                    fiq_out
);
    typedef struct packed {
        logic [N_IRQ-1:0] pend;
        logic [N_IRQ-1:0] act;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [1:0]       dctl;
    logic [3:0]       cctl;
    logic [N_IRQ-1:0] grp_ok, cand, pend_vec, act_vec;
    logic             top_found, top_grp1, ack_allowed, ack_rd, eoi_wr, eoi_hit, eoi_ok;
    logic [IDX_W-1:0] top_id, eoi_idx;
    logic [ID_W-1:0]  ack_id, eoi_id;

    irq_ctl_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_valid && bus_write),
        .sel    (bus_addr),
        .wdata  (bus_wdata[3:0]),
        .secure (bus_secure),
        .dctl   (dctl),
        .cctl   (cctl)
    );

    always_comb begin
        for (int i = 0; i < N_IRQ; i++) begin
            grp_ok[i] = irq_group[i] ? (dctl[1] && cctl[CC_EN1])
                                     : (dctl[0] && cctl[CC_EN0]);
        end
    end

    assign cand = st_q.pend & ~st_q.act & grp_ok;

    irq_prio_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .cand    (cand),
        .prio    (irq_prio),
        .found   (top_found),
        .best_id (top_id)
    );

    assign top_grp1    = irq_group[top_id];
    assign ack_allowed = top_found &&
                         (bus_secure ? (!top_grp1 || cctl[CC_ACKCTL]) : top_grp1);
    assign ack_id      = ack_allowed ? {{(ID_W-IDX_W){1'b0}}, top_id} : SPURIOUS_ID;
    assign ack_rd      = bus_valid && !bus_write && (bus_addr == SEL_ACK);
    assign eoi_wr      = bus_valid && bus_write && (bus_addr == SEL_EOI);
    assign eoi_id      = bus_wdata[ID_W-1:0];
    assign eoi_hit     = eoi_id < ID_W'(N_IRQ);
    assign eoi_idx     = eoi_id[IDX_W-1:0];
    assign eoi_ok      = eoi_wr && eoi_hit && (bus_secure || irq_group[eoi_idx]);

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | irq_pend_set;
        if (ack_rd && ack_allowed) begin
            st_d.pend[top_id] = 1'b0;
            st_d.act[top_id]  = 1'b1;
        end
        if (eoi_ok) begin
            st_d.act[eoi_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SEL_DCTL: bus_rdata[1:0] = bus_secure ? dctl : {1'b0, dctl[1]};
            SEL_CCTL: bus_rdata[3:0] = bus_secure ? cctl : {3'b000, cctl[CC_EN1]};
            SEL_ACK:  bus_rdata[ID_W-1:0] = ack_id;
            SEL_ACTV: bus_rdata[N_IRQ-1:0] = st_q.act;
            SEL_PEND: bus_rdata[N_IRQ-1:0] = st_q.pend;
            default:  bus_rdata = '0;
        endcase
    end

    assign fiq_out  = top_found && !top_grp1 && cctl[CC_FIQEN];
    assign irq_out  = top_found && !(!top_grp1 && cctl[CC_FIQEN]);
    assign pend_vec = st_q.pend;
    assign act_vec  = st_q.act;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int N_IRQ  = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             bus_secure,
    input logic [31:0]      bus_rdata,
    input logic [N_IRQ-1:0] irq_pend_set,
    input logic [N_IRQ-1:0] irq_group,
    input logic             irq_out,
    input logic             fiq_out,
    input logic [3:0]       cctl,
    input logic [N_IRQ-1:0] pend_vec,
    input logic [N_IRQ-1:0] act_vec
);
    logic ack_rd, eoi_wr, spur;
    assign ack_rd = bus_valid && !bus_write && bus_addr == 3'd2;
    assign eoi_wr = bus_valid && bus_write && bus_addr == 3'd3;
    assign spur   = bus_rdata[9:0] == 10'd1023;

    a_r9_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_out && fiq_out));
    a_r9_fiq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out |-> cctl[3]);
    a_r5_ns_ack_grp1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !bus_secure && !spur) |-> irq_group[bus_rdata[IDX_W-1:0]]);
    a_r6_sec_grp1_ackctl: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && bus_secure && !spur && irq_group[bus_rdata[IDX_W-1:0]]) |-> cctl[2]);
    a_r7_spurious_still: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && spur && irq_pend_set == '0) |=> ($stable(pend_vec) && $stable(act_vec)));
    a_r7_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !spur) |=> act_vec[$past(bus_rdata[IDX_W-1:0])]);
    a_r8_ns_eoi_grp0: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !bus_secure && bus_wdata[9:0] < 10'(N_IRQ)
         && !irq_group[bus_wdata[IDX_W-1:0]]) |=> $stable(act_vec));
endmodule

bind irq_gate_ctrl irq_gate_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_secure   (bus_secure),
    .bus_rdata    (bus_rdata),
    .irq_pend_set (irq_pend_set),
    .irq_group    (irq_group),
    .irq_out      (irq_out),
    .fiq_out      (fiq_out),
    .cctl         (cctl),
    .pend_vec     (pend_vec),
    .act_vec      (act_vec)
);

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;
    localparam int N = 8;
    localparam int PW = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_valid = 0, bus_write = 0, bus_secure = 0;
    logic [2:0]    bus_addr = 0;
    logic [31:0]   bus_wdata = 0, bus_rdata;
    logic [N-1:0]  irq_pend_set = 0;
    logic [N-1:0]  irq_group = 8'hF0;
    logic [N*PW-1:0] irq_prio = '1;
    logic          irq_out, fiq_out;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    irq_gate_ctrl #(.N_IRQ(N), .PRIO_W(PW)) i_irq_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(bus_rdata), .irq_pend_set(irq_pend_set), .irq_group(irq_group),
        .irq_prio(irq_prio), .irq_out(irq_out), .fiq_out(fiq_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_secure = s;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic s, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_secure = s;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic pend(input logic [N-1:0] m);
        @(negedge clk);
        irq_pend_set = m;
        @(negedge clk);
        irq_pend_set = '0;
    endtask

    task automatic set_prio(input int id, input logic [PW-1:0] p);
        irq_prio[id*PW +: PW] = p;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 fiq", {31'b0, fiq_out}, 0);
        rd(3'd0, 1, d); chk("R1 dctl", d, 0);
        rd(3'd1, 1, d); chk("R1 cctl", d, 0);
        rd(3'd2, 1, d); chk("R1 ack spurious", d, 1023);
        rd(3'd4, 1, d); chk("R1 active", d, 0);
    endtask

    task automatic t_banks();
        logic [31:0] d;
        wr(3'd0, 3, 1);
        rd(3'd0, 1, d); chk("R2 secure view", d, 3);
        rd(3'd0, 0, d); chk("R2 ns alias", d, 1);
        wr(3'd0, 0, 0);
        rd(3'd0, 1, d); chk("R2 ns write bit1 only", d, 1);
        wr(3'd0, 1, 0);
        rd(3'd0, 1, d); chk("R2 ns set", d, 3);
        wr(3'd1, 32'hF, 1);
        rd(3'd1, 1, d); chk("R3 secure view", d, 32'hF);
        rd(3'd1, 0, d); chk("R3 ns alias", d, 1);
        wr(3'd1, 0, 0);
        rd(3'd1, 1, d); chk("R3 ns write", d, 32'hD);
        wr(3'd1, 3, 1);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        set_prio(1, 9); set_prio(2, 5); set_prio(3, 5);
        pend(8'h0E);
        rd(3'd2, 1, d); chk("R4 tie lowest id", d, 2);
        rd(3'd2, 1, d); chk("R4 next", d, 3);
        rd(3'd2, 1, d); chk("R4 last", d, 1);
        rd(3'd4, 1, d); chk("R7 active set", d, 32'h0E);
        rd(3'd5, 1, d); chk("R7 pending cleared", d, 0);
        rd(3'd2, 1, d); chk("R7 empty spurious", d, 1023);
        rd(3'd4, 1, d); chk("R7 spurious no change", d, 32'h0E);
        wr(3'd3, 1, 1); wr(3'd3, 2, 1); wr(3'd3, 3, 1);
        rd(3'd4, 1, d); chk("R8 secure eoi", d, 0);
    endtask

    task automatic t_ns_ack();
        logic [31:0] d;
        set_prio(0, 3); set_prio(5, 8);
        pend(8'h21);
        rd(3'd2, 0, d); chk("R5 ns ack grp0 top", d, 1023);
        rd(3'd5, 1, d); chk("R7 pend kept", d, 32'h21);
        rd(3'd2, 1, d); chk("R5 secure ack grp0", d, 0);
        rd(3'd2, 0, d); chk("R5 ns ack grp1", d, 5);
        rd(3'd4, 1, d); chk("R7 active", d, 32'h21);
    endtask

    task automatic t_eoi();
        logic [31:0] d;
        wr(3'd3, 0, 0);
        rd(3'd4, 1, d); chk("R8 ns eoi grp0 ignored", d, 32'h21);
        wr(3'd3, 5, 0);
        rd(3'd4, 1, d); chk("R8 ns eoi grp1", d, 32'h01);
        wr(3'd3, 0, 1);
        rd(3'd4, 1, d); chk("R8 secure eoi grp0", d, 0);
    endtask

    task automatic t_ackctl();
        logic [31:0] d;
        set_prio(6, 2);
        pend(8'h40);
        rd(3'd2, 1, d); chk("R6 no ackctl", d, 1023);
        wr(3'd1, 7, 1);
        rd(3'd2, 1, d); chk("R6 ackctl", d, 6);
        wr(3'd1, 3, 1);
        wr(3'd3, 6, 1);
        rd(3'd4, 1, d); chk("R8 secure eoi grp1 ackctl0", d, 0);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        set_prio(1, 6); set_prio(4, 0);
        pend(8'h02);
        chk("R9 irq grp0", {30'b0, irq_out, fiq_out}, 2'b10);
        wr(3'd1, 32'hB, 1);
        chk("R9 fiq grp0", {30'b0, irq_out, fiq_out}, 2'b01);
        wr(3'd0, 2, 1);
        chk("R4 grp0 disabled", {30'b0, irq_out, fiq_out}, 2'b00);
        wr(3'd0, 3, 1);
        pend(8'h10);
        chk("R9 grp1 irq", {30'b0, irq_out, fiq_out}, 2'b10);
        wr(3'd1, 32'hF, 1);
        rd(3'd2, 1, d); chk("R9 ack 4", d, 4);
        rd(3'd2, 1, d); chk("R9 ack 1", d, 1);
        chk("R9 none", {30'b0, irq_out, fiq_out}, 2'b00);
        wr(3'd3, 4, 1); wr(3'd3, 1, 1);
        wr(3'd1, 3, 1);
    endtask

    task automatic t_repend();
        logic [31:0] d;
        pend(8'h04);
        rd(3'd2, 1, d); chk("R10 first ack", d, 2);
        pend(8'h04);
        rd(3'd2, 1, d); chk("R10 active not eligible", d, 1023);
        rd(3'd5, 1, d); chk("R10 pending again", d, 32'h04);
        wr(3'd3, 2, 1);
        rd(3'd2, 1, d); chk("R10 eligible after eoi", d, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_banks();
        t_arb();
        t_ns_ack();
        t_eoi();
        t_ackctl();
        t_fiq();
        t_repend();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule